// File: doc/BRIEF.md
# SMBus Slave Register Access Port

This block is a serial management bus slave that lets a host controller read and write an internal bank of 8-bit registers. It watches oversampled clock and data lines, detects START and STOP conditions, and answers a 7-bit device address. The upper five address bits are fixed at 01011. The two low bits come from a strap that is captured while reset is held.

Every write transaction first loads a shared pointer register. An optional second byte, and any byte after it, is written to the register that the pointer selects. A read transaction returns the register at the current pointer, so one pointer write is enough for any number of reads. The pointer never advances by itself. The block also answers the alert-response address while its alert input is pending. It returns its own address and pulses an alert-served output.

The register file sits outside the block. The read port is combinational: the block presents `rf_addr` and samples `rf_rdata` in the same cycle. The write port is a single-cycle valid strobe (`rf_wvalid`) with no ready. The bus cannot be held off here, because clock stretching is not supported, so the register file must take a write in any cycle. There is no back-pressure in either direction.

Top module: `smb_regport`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `rf_wvalid`=0, `alert_served`=0 and the pointer (`rf_addr`) is 0.
- R2: An address byte whose upper seven bits equal {01011, strap} is acknowledged: SDA is driven low during the 9th clock. Any other address, except the alert case of R7, is not acknowledged, and the block ignores the bus until the next START.
- R3: The first byte after a write address (R/W bit 0) is stored into the pointer and acknowledged. A transaction carrying only that byte produces no register write.
- R4: Each further byte of a write transaction is acknowledged and written, with a one-cycle `rf_wvalid`, to the register at the pointer. The pointer does not increment, so later bytes overwrite the same register.
- R5: A read transaction (R/W bit 1) returns the register at the current pointer, MSB first. This holds also when the pointer was set by an earlier transaction.
- R6: After a read byte, a master ACK (SDA low at the 9th clock) causes the same register to be sent again. A master NACK makes the block release SDA and stay silent until the next START.
- R7: While `alert_pend`=1, a read from address 0001100 is acknowledged and returns {own 7-bit address, 0}. The block then pulses `alert_served` for exactly one cycle. While `alert_pend`=0 that address is not acknowledged.
- R8: A START detected in the middle of a byte discards it, and address reception restarts.
- R9: The strap is sampled only while reset is asserted. A later change of `addr_strap` has no effect on the matched address.
- R10: The block begins driving SDA low only while SCL is low, and it never drives SDA while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_strap | input | 2 | Low two bits of the device address, captured during reset |
| rf_addr | output | 8 | Register address, equal to the pointer |
| rf_rdata | input | 8 | Register read data for `rf_addr` (combinational) |
| rf_wdata | output | 8 | Register write data |
| rf_wvalid | output | 1 | One-cycle write strobe; always accepted |
| alert_pend | input | 1 | Alert is pending; enables the alert-response address |
| alert_served | output | 1 | One-cycle pulse after the alert response byte is sent |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and the default fixed address bits. With these defaults the device answers at 0x2E for strap 2'b10. The bench runs the bus with a quarter-period of four system clocks, which leaves room for the synchronizer and register latency inside each SCL low phase. This setting makes every corner reachable: pointer-only writes, multi-byte writes, repeated reads, the alert address with and without a pending alert, a restart inside an address byte, and a strap change after reset.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } eng_st_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_s,
  output logic [LINES-1:0] line_q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain     <= '1;
        line_q[g] <= 1'b1;
      end else begin
        chain     <= {chain[STAGES-2:0], line_i[g]};
        line_q[g] <= chain[STAGES-1];
      end
    end
    assign line_s[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/smb_cond.sv
module smb_cond (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        own_addr,
  input  logic              alert_pend,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic [BYTE_W-1:0] wdata,
  output logic              wvalid,
  output logic              served,
  output logic              busy
);
  eng_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw, ara, first, more, srv_done;
  logic              hit_own, hit_ara;
  logic [BYTE_W-1:0] tx_src;

  assign hit_own = (sh[7:1] == own_addr);
  assign hit_ara = (sh[7:1] == ARA_ADDR) && sh[0] && alert_pend;
  assign tx_src  = ara ? {own_addr, 1'b0} : rf_rdata;
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      ara      <= 1'b0;
      first    <= 1'b1;
      more     <= 1'b0;
      srv_done <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wdata    <= '0;
      wvalid   <= 1'b0;
      served   <= 1'b0;
    end else begin
      wvalid <= 1'b0;
      served <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        first    <= 1'b1;
        ara      <= 1'b0;
        more     <= 1'b0;
        srv_done <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != CNT_W'(BYTE_W)) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              if (st == ST_ADDR) begin
                if (hit_own || hit_ara) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  ara    <= hit_ara;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                if (first) ptr <= sh;
                else begin
                  wdata  <= sh;
                  wvalid <= 1'b1;
                end
                first  <= 1'b0;
                sda_oe <= 1'b1;
                st     <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx     <= tx_src;
                sda_oe <= ~tx_src[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                more   <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (ara && !srv_done) begin
                served   <= 1'b1;
                srv_done <= 1'b1;
              end
              if (sda_s) st <= ST_IDLE;
              else       more <= 1'b1;
            end else if (scl_fall && more) begin
              tx     <= tx_src;
              sda_oe <= ~tx_src[BYTE_W-1];
              cnt    <= CNT_W'(1);
              st     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regport.sv
module smb_regport
  import smb_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_HI      = 5'b01011,
  parameter logic [6:0] ARA_ADDR    = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_strap,
  output logic [BYTE_W-1:0] rf_addr,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic              rf_wvalid,
  input  logic              alert_pend,
  output logic              alert_served
);
  logic [1:0] line_s, line_q;
  logic       scl_s, scl_rise, scl_fall, start_det, stop_det, busy;
  logic [1:0] strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= addr_strap;
  end

  smb_sync #(.STAGES(SYNC_STAGES), .LINES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .line_i({sda_i, scl_i}),
    .line_s(line_s), .line_q(line_q)
  );

  assign scl_s = line_s[0];

  smb_cond i_cond (
    .scl_s(line_s[0]), .scl_q(line_q[0]), .sda_s(line_s[1]), .sda_q(line_q[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_engine #(.ARA_ADDR(ARA_ADDR)) i_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(line_s[1]), .start_det(start_det), .stop_det(stop_det),
    .own_addr({DEV_HI, strap_q}), .alert_pend(alert_pend), .rf_rdata(rf_rdata),
    .sda_oe(sda_oe), .ptr(rf_addr), .wdata(rf_wdata), .wvalid(rf_wvalid),
    .served(alert_served), .busy(busy)
  );
endmodule

// File: rtl/smb_regport_chk.sv
module smb_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic busy,
  input logic sda_oe,
  input logic rf_wvalid,
  input logic alert_pend,
  input logic alert_served
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe); // R10
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wvalid |=> !rf_wvalid); // R4
  AST_WRITE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wvalid |-> $past(scl_fall)); // R4
  AST_SERVED_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    alert_served |-> alert_pend); // R7
  AST_SERVED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_served |=> !alert_served); // R7
endmodule

bind smb_regport smb_regport_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall), .busy(busy),
  .sda_oe(sda_oe), .rf_wvalid(rf_wvalid), .alert_pend(alert_pend),
  .alert_served(alert_served)
);

// File: tb/test_smb_regport.sv
module test_smb_regport;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, rf_wvalid, alert_pend = 1'b0, alert_served;
  logic [1:0] addr_strap = 2'b10;
  logic [7:0] rf_addr, rf_rdata, rf_wdata;
  logic sda_bus;
  logic [7:0] rfile [256];
  logic [7:0] model [256];
  int checks = 0, failures = 0, wcount = 0, scount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus  = m_sda & ~sda_oe;
  assign rf_rdata = rfile[rf_addr];

  smb_regport i_smb_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(addr_strap), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .rf_wdata(rf_wdata), .rf_wvalid(rf_wvalid), .alert_pend(alert_pend),
    .alert_served(alert_served)
  );

  always @(posedge clk) begin
    if (rf_wvalid) begin
      rfile[rf_addr] <= rf_wdata;
      wcount <= wcount + 1;
    end
    if (alert_served) scount <= scount + 1;
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic r);
    return {a, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); b = sda_bus; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(2*Q); m_sda = 1'b0; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(2*Q); m_sda = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~mack);
  endtask

  logic [6:0] own;
  logic nk;
  logic [7:0] rd, rd2, p, d;
  int wc0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      rfile[i] = init_val(i);
      model[i] = init_val(i);
    end
    void'($urandom(32'd4242));
    own = {5'b01011, 2'b10};
    w(6); rst_n = 1'b1; w(4);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 wvalid", rf_wvalid, 0);
    chk("R1 served", alert_served, 0);
    chk("R1 ptr", rf_addr, 0);

    // R2 R3 pointer-only write
    wc0 = wcount;
    bus_start(); send_byte(addr_byte(own, 0), nk); chk("R2 addr ack", nk, 0);
    send_byte(8'h10, nk); chk("R3 ptr ack", nk, 0); bus_stop();
    chk("R3 ptr loaded", rf_addr, 8'h10);
    chk("R3 no write", wcount - wc0, 0);

    // R5 read at pointer set earlier
    bus_start(); send_byte(addr_byte(own, 1), nk); chk("R5 addr ack", nk, 0);
    recv_byte(0, rd); bus_stop();
    chk("R5 read", rd, model[8'h10]);
    chk("R6 released after nack", sda_oe, 0);

    // R4 two data bytes go to same register
    wc0 = wcount;
    bus_start(); send_byte(addr_byte(own, 0), nk);
    send_byte(8'h20, nk); send_byte(8'hA5, nk); chk("R4 data ack", nk, 0);
    send_byte(8'h3C, nk); bus_stop();
    model[8'h20] = 8'h3C;
    chk("R4 write count", wcount - wc0, 2);
    chk("R4 no increment", rf_addr, 8'h20);
    chk("R4 reg", rfile[8'h20], 8'h3C);
    chk("R4 neighbour", rfile[8'h21], model[8'h21]);

    // R6 master ACK repeats same register
    bus_start(); send_byte(addr_byte(own, 1), nk);
    recv_byte(1, rd); recv_byte(0, rd2); bus_stop();
    chk("R6 first", rd, 8'h3C);
    chk("R6 repeat", rd2, 8'h3C);

    // R2 wrong address ignored
    wc0 = wcount;
    bus_start(); send_byte(addr_byte(7'h2F, 0), nk); chk("R2 no ack", nk, 1);
    send_byte(8'h44, nk); send_byte(8'h99, nk); bus_stop();
    chk("R2 ignored ptr", rf_addr, 8'h20);
    chk("R2 ignored write", wcount - wc0, 0);

    // R9 strap change after reset
    addr_strap = 2'b01; w(4);
    bus_start(); send_byte(addr_byte(7'h2D, 0), nk); bus_stop();
    chk("R9 new strap unmatched", nk, 1);
    bus_start(); send_byte(addr_byte(own, 0), nk); bus_stop();
    chk("R9 old strap matched", nk, 0);

    // R7 alert response address
    bus_start(); send_byte(addr_byte(7'h0C, 1), nk); bus_stop();
    chk("R7 no alert no ack", nk, 1);
    alert_pend = 1'b1;
    bus_start(); send_byte(addr_byte(7'h0C, 1), nk); chk("R7 ack", nk, 0);
    recv_byte(0, rd); bus_stop(); w(4);
    chk("R7 own address", rd, {own, 1'b0});
    chk("R7 served pulses", scount, 1);
    alert_pend = 1'b0;

    // R8 restart inside address byte
    bus_start(); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start(); send_byte(addr_byte(own, 0), nk); chk("R8 ack after restart", nk, 0);
    send_byte(8'h30, nk); bus_stop();
    chk("R8 ptr", rf_addr, 8'h30);

    // random traffic, R3 R4 R5
    for (int k = 0; k < 24; k++) begin
      p = 8'($urandom); d = 8'($urandom);
      bus_start(); send_byte(addr_byte(own, 0), nk); send_byte(p, nk);
      if ($urandom % 2 == 1) begin
        send_byte(d, nk); model[p] = d;
      end
      bus_stop();
      bus_start(); send_byte(addr_byte(own, 1), nk); recv_byte(0, rd); bus_stop();
      chk("R5 random read", rd, model[p]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule